// File: doc/BRIEF.md
# XOR Sprite Blitter with Collision Detect

The block draws monochrome sprites into a 64-column by 32-row frame buffer that holds one bit per pixel. A draw names a start column, a start row, a row count of 0 to 15 and a base address in byte memory. The block reads one byte per sprite row. It walks the byte from its most significant bit, which is the leftmost pixel, and inverts the frame-buffer pixel under every set bit. Pixel coordinates wrap around both edges of the screen. A collision flag is raised when any inverted pixel was lit beforehand.

A separate clear command blanks the whole frame buffer in one cycle. A row-wide view port lets a video or test reader fetch any frame-buffer row combinationally. The memory read port has one cycle of latency. Each sprite row costs exactly 9 cycles: one cycle to issue the read, then eight pixel cycles.

Top module: `xor_sprite_blit`

## Requirements
- R1: After reset, busy, done and collision are 0, mem_rd is 0, and every frame-buffer pixel is 0.
- R2: Sprite row r comes from the byte at address (spr_base + r) modulo 4096. Bit 7 of that byte is the pixel at column org_x, and bit 0 is the pixel at org_x + 7. A set bit inverts its pixel and a clear bit leaves its pixel unchanged.
- R3: The pixel for row r and bit position k is at column (org_x + k) mod 64 and row (org_y + r) mod 32.
- R4: Accepting a draw clears collision. Collision becomes 1 if any inverted pixel was 1 before it was inverted, and it holds its value until the next accepted draw.
- R5: While the block is idle, clr sets every pixel to 0 in one cycle. If start is also high in that cycle, clr wins and start is ignored. While busy, clr is ignored.
- R6: A start while busy is ignored and does not change the draw in progress.
- R7: A draw of n ≥ 1 rows, accepted at a clock edge, keeps busy high for exactly 9·n cycles. done pulses for one cycle as busy falls, and the final collision value is valid at that point.
- R8: A draw of 0 rows never raises busy. It pulses done on the cycle after acceptance, reports collision 0 and leaves all pixels unchanged.
- R9: Each sprite row issues exactly one single-cycle mem_rd with mem_addr valid. mem_data is taken on the following cycle.
- R10: view_bits bit c equals the pixel at column c of row view_row, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Draw request, taken when idle |
| org_x | input | 6 | Start column |
| org_y | input | 5 | Start row |
| n_rows | input | 4 | Sprite rows to draw (0 to 15) |
| spr_base | input | 12 | Byte address of the first sprite row |
| clr | input | 1 | Blank the frame buffer (idle only) |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | A lit pixel was turned off by the last draw |
| mem_rd | output | 1 | Sprite memory read strobe |
| mem_addr | output | 12 | Sprite memory read address |
| mem_data | input | 8 | Read data, valid one cycle after mem_rd |
| view_row | input | 5 | Frame-buffer row to observe |
| view_bits | output | 64 | Pixels of view_row, bit c is column c |

## Verification
A wrong row pointer or wrong wrap arithmetic leaves whole bytes of pixels in the wrong frame-buffer row or column. This shows on view_bits as soon as the draw finishes. A pixel counter that is off by one changes the busy length away from 9·n, and done then arrives in the wrong cycle. A stale collision register shows as a wrong collision level at the done pulse, especially on a zero-row draw that follows a colliding one. Clear or start commands that leak into a running draw alter the frame or the collision result of that same draw.

// File: rtl/xor_sprite_blit.sv
module xor_sprite_blit #(
  parameter int FB_W  = 64,
  parameter int FB_H  = 32,
  parameter int AW    = 12,
  parameter int NW    = 4,
  parameter int SPR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [5:0]        org_x,
  input  logic [4:0]        org_y,
  input  logic [NW-1:0]     n_rows,
  input  logic [AW-1:0]     spr_base,
  input  logic              clr,
  output logic              busy,
  output logic              done,
  output logic              collision,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [SPR_W-1:0]  mem_data,
  input  logic [4:0]        view_row,
  output logic [FB_W-1:0]   view_bits
);
  localparam int XW = $clog2(FB_W);
  localparam int YW = $clog2(FB_H);
  localparam int PW = $clog2(SPR_W);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_PIX} st_t;

  st_t             st;
  logic [FB_W-1:0] fb [FB_H];
  logic [XW-1:0]   col_q;
  logic [YW-1:0]   cur_y;
  logic [AW-1:0]   addr_q;
  logic [NW-1:0]   left;
  logic [PW-1:0]   pix_k;
  logic [SPR_W-1:0] sh_q;

  wire [SPR_W-1:0] cur_bits = (pix_k == '0) ? mem_data : sh_q;
  wire [XW-1:0]    px       = col_q + XW'(pix_k);
  wire             last_pix = (pix_k == PW'(SPR_W - 1));
  wire             take     = (st == S_IDLE) && start && !clr;

  assign busy      = (st != S_IDLE);
  assign mem_rd    = (st == S_RD);
  assign mem_addr  = addr_q;
  assign view_bits = fb[view_row[YW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      collision <= 1'b0;
      col_q     <= '0;
      cur_y     <= '0;
      addr_q    <= '0;
      left      <= '0;
      pix_k     <= '0;
      sh_q      <= '0;
      for (int i = 0; i < FB_H; i++) fb[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (clr) begin
            for (int i = 0; i < FB_H; i++) fb[i] <= '0;
          end else if (take) begin
            collision <= 1'b0;
            col_q     <= org_x[XW-1:0];
            cur_y     <= org_y[YW-1:0];
            addr_q    <= spr_base;
            left      <= n_rows;
            pix_k     <= '0;
            if (n_rows == '0) done <= 1'b1;
            else              st   <= S_RD;
          end
        end
        S_RD: begin
          pix_k <= '0;
          st    <= S_PIX;
        end
        S_PIX: begin
          sh_q  <= cur_bits << 1;
          pix_k <= pix_k + 1'b1;
          if (cur_bits[SPR_W-1]) begin
            fb[cur_y][px] <= ~fb[cur_y][px];
            if (fb[cur_y][px]) collision <= 1'b1;
          end
          if (last_pix) begin
            if (left == NW'(1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              left   <= left - 1'b1;
              addr_q <= addr_q + 1'b1;
              cur_y  <= cur_y + 1'b1;
              st     <= S_RD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(col_q));

  // R8
  zero_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !clr && n_rows == '0) |=> (done && !busy));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !busy) |=> (view_bits == '0 && !busy));

  // R4
  coll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !clr) |=> !collision);
endmodule

// File: tb/test_xor_sprite_blit.sv
module test_xor_sprite_blit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  org_x = '0;
  logic [4:0]  org_y = '0;
  logic [3:0]  n_rows = '0;
  logic [11:0] spr_base = '0;
  logic        clr = 1'b0;
  logic        busy, done, collision, mem_rd;
  logic [11:0] mem_addr;
  logic [7:0]  mem_data;
  logic [4:0]  view_row = '0;
  logic [63:0] view_bits;

  logic [7:0]  mem [4096];
  logic [63:0] ref_fb [32];
  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  xor_sprite_blit i_xor_sprite_blit (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .n_rows(n_rows), .spr_base(spr_base), .clr(clr), .busy(busy), .done(done),
    .collision(collision), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .view_row(view_row), .view_bits(view_bits));

  always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr];
  always @(negedge clk) if (mem_rd) rd_cnt++;

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run hung act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic ref_draw(input int cx, input int cy, input int n, input int base);
    logic c = 1'b0;
    for (int r = 0; r < n; r++) begin
      logic [7:0] b = mem[(base + r) % 4096];
      for (int k = 0; k < 8; k++) begin
        if (b[7-k]) begin
          int x = (cx + k) % 64;
          int y = (cy + r) % 32;
          if (ref_fb[y][x]) c = 1'b1;
          ref_fb[y][x] = ~ref_fb[y][x];
        end
      end
    end
    return c;
  endfunction

  task automatic cmp_frame(input string req);
    int bad = 0;
    logic [63:0] a = '0, e = '0;
    for (int y = 0; y < 32; y++) begin
      view_row = 5'(y);
      #1;
      if (view_bits !== ref_fb[y] && bad == 0) begin
        bad = 1; a = view_bits; e = ref_fb[y];
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s frame row act=%h exp=%h", req, a, e);
    end
  endtask

  // mode 0 plain, 1 clr during busy, 2 start during busy
  task automatic draw(input int cx, input int cy, input int n, input int base, input int mode, input string req);
    logic exp_c;
    int cyc = 0, bcnt = 0, rd0;
    exp_c = ref_draw(cx, cy, n, base);
    @(negedge clk);
    rd0 = rd_cnt;
    org_x = 6'(cx); org_y = 5'(cy); n_rows = 4'(n); spr_base = 12'(base);
    start = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      clr = 1'b0;
      if (cyc == 3 && mode == 1) clr = 1'b1;
      if (cyc == 3 && mode == 2) begin
        start = 1'b1; org_x = 6'(cx + 5); org_y = 5'(cy + 3); n_rows = 4'd1; spr_base = 12'(base + 7);
      end
      if (busy) bcnt++;
      if (done) break;
      if (cyc > 200) break;
    end
    start = 1'b0; clr = 1'b0;
    chk({req, " R7 done cycle"}, 64'(cyc), 64'(9 * n + 1));
    chk({req, " R7 busy length"}, 64'(bcnt), 64'(9 * n));
    chk({req, " R4 collision"}, 64'(collision), 64'(exp_c));
    chk({req, " R9 read count"}, 64'(rd_cnt - rd0), 64'(n));
    @(negedge clk);
    chk({req, " R7 done one pulse"}, 64'(done), 64'd0);
    cmp_frame({req, " R2 R3 frame"});
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int a = 0; a < 4096; a++) mem[a] = 8'($urandom);
    for (int y = 0; y < 32; y++) ref_fb[y] = '0;
    mem_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 collision", 64'(collision), 0);
    chk("R1 mem_rd", 64'(mem_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_frame("R1 R10 reset frame");

    // R2 single leftmost pixel
    mem[100] = 8'h80;
    draw(0, 0, 1, 100, 0, "R2 msb first");
    view_row = 0; #1;
    chk("R10 pixel 0,0", view_bits, 64'h1);
    // R4 redraw turns it off
    draw(0, 0, 1, 100, 0, "R4 collide");
    chk("R4 collision set", 64'(collision), 1);
    // R8 zero rows clears collision, no change
    draw(5, 5, 0, 0, 0, "R8 zero rows");
    chk("R8 collision zero", 64'(collision), 0);
    // R3 wrap both axes
    mem[200] = 8'hFF; mem[201] = 8'hA5; mem[202] = 8'h81;
    draw(62, 31, 3, 200, 0, "R3 wrap");
    // R2 address wrap
    mem[4095] = 8'h3C; mem[0] = 8'hC3;
    draw(10, 4, 2, 4095, 0, "R2 addr wrap");
    // R5 clr while busy ignored
    draw(20, 8, 4, 300, 1, "R5 clr busy");
    // R6 start while busy ignored
    draw(30, 12, 5, 400, 2, "R6 start busy");
    // R5 clr with start: clr wins
    @(negedge clk);
    clr = 1'b1; start = 1'b1; n_rows = 4'd2; spr_base = 12'd200;
    @(negedge clk);
    clr = 1'b0; start = 1'b0;
    for (int y = 0; y < 32; y++) ref_fb[y] = '0;
    chk("R5 start ignored with clr", 64'(busy | done), 0);
    cmp_frame("R5 clear frame");
    // random draws
    for (int t = 0; t < 40; t++) begin
      draw(int'($urandom_range(0, 63)), int'($urandom_range(0, 31)),
           int'($urandom_range(0, 15)), int'($urandom_range(0, 4095)),
           int'($urandom_range(0, 2)) * ((t % 3 == 0) ? 1 : 0), "R2 random");
      if (t == 20) begin
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        for (int y = 0; y < 32; y++) ref_fb[y] = '0;
        cmp_frame("R5 mid clear");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule